// File: doc/BRIEF.md
# Management Port Device Responder

This block models the device end of a three-register management port. A host reaches it through a small register bus: offset 0 is the data byte, offset 1 is the control code (write) and status code (read), offset 2 is the flags byte. The host places a byte in the data register, puts a control code in the control register, and then sets the busy bit in flags. The responder treats this as a command. After a fixed response delay it clears busy and, in that same cycle, shows the status code, data byte and ready flags that answer the command.

A request phase collects the host's bytes into a request buffer. A response phase then returns bytes from a response buffer that the test loads beforehand. The completion code of each phase appears in the data register. The block is meant to sit opposite a host-side port engine in self-checking tests. It does not interpret message contents and it only answers the normal host stream.

Top module: `mgmt_port_responder`

## Requirements
- R1: After reset, status reads 0xC0, data reads 0x00, and flags read 0x00 apart from bit 2, which follows `sms_avail_i`.
- R2: Flags bit layout: bit 7 is response byte ready, bit 6 is request room ready, bit 2 follows `sms_avail_i`, and bit 0 is busy. Bits 5, 4, 3 and 1 always read zero, so flags can never read 0xFF.
- R3: A host write to flags with bit 0 set while the block is not busy sets busy in the next cycle. Busy clears exactly `RESP_DELAY` cycles after it rose. The new status, data and flags appear in the cycle busy clears, and status and data hold while busy is set.
- R4: While busy is set, host writes to any register are ignored. The running command still completes using the control code and data byte latched before it started.
- R5: Control 0x40 (get status) in the ready phase answers status 0xC0 with data 0x00.
- R6: Control 0x41 (write start) in the ready phase stores the data byte as request byte 0 and answers 0xC1. Control 0x42 (write next) appends the byte and answers 0xC2. After either, bit 6 is set while the request buffer still has room.
- R7: Control 0x43 (write end) appends the final byte and answers 0xC3 with completion code 0x00 in data. It clears bit 6. It sets bit 7 only when `rsp_len` is at least 2.
- R8: Control 0x44 (read start) after a write end answers 0xC4 and presents response byte 0 in data. Each control 0x45 (read next) presents the following byte. It answers 0xC5, or 0xC6 when that byte is the last of `rsp_len`. Bit 7 stays set throughout.
- R9: Control 0x46 (read end) after the last byte has been presented answers 0xC0 with completion code 0x00 and clears bit 7.
- R10: Any other control code, or any code that does not fit the current phase, resets the block to the ready phase. This includes codes with bit 7 set, the 0x60 stream, and step values above 6. The block answers status 0xC0 with completion code 0x02 and clears bits 7 and 6.
- R11: A write next or write end sent when the request buffer already holds `BUF_DEPTH` bytes stores nothing. It answers 0xC0 with completion code 0x05 and returns the block to the ready phase.
- R12: `req_count` gives the number of request bytes captured, and `req_peek_byte` gives the byte at `req_peek_idx`. Response bytes are loaded through `rsp_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset: 0 data, 1 control/status, 2 flags |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sms_avail_i | input | 1 | Level shown in flags bit 2 |
| rsp_load | input | 1 | Write strobe for the response buffer |
| rsp_load_idx | input | IDXW | Response buffer index to load |
| rsp_load_byte | input | 8 | Response byte to load |
| rsp_len | input | LENW | Number of valid response bytes |
| req_peek_idx | input | IDXW | Request buffer index to observe |
| req_peek_byte | output | 8 | Request byte at `req_peek_idx` |
| req_count | output | LENW | Request bytes captured |

## Verification
A flags write with busy set is registered at one edge. Busy reads high from that edge on, and every result of the command (status, data, flags, request capture) lands on the edge `RESP_DELAY` cycles later. The bench therefore issues each command from the falling edge, waits exactly `RESP_DELAY` falling edges, and samples there. The busy-timing test also samples one falling edge earlier, where busy must still be set. Writes made inside the busy window are checked against the command that was already running.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    typedef enum logic [1:0] {
        PH_READY,
        PH_WRITE,
        PH_RESP,
        PH_READ
    } phase_t;

    localparam logic [3:0] STEP_READY    = 4'd0;
    localparam logic [3:0] STEP_WR_START = 4'd1;
    localparam logic [3:0] STEP_WR_NEXT  = 4'd2;
    localparam logic [3:0] STEP_WR_END   = 4'd3;
    localparam logic [3:0] STEP_RD_START = 4'd4;
    localparam logic [3:0] STEP_RD_NEXT  = 4'd5;
    localparam logic [3:0] STEP_RD_END   = 4'd6;

    // upper nibble of a legal host control code (control form, host stream)
    localparam logic [3:0] CTRL_HI = 4'b0100;

    localparam logic [7:0] CC_OK      = 8'h00;
    localparam logic [7:0] CC_ILLEGAL = 8'h02;
    localparam logic [7:0] CC_FULL    = 8'h05;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_FLAGS = 2'd2;

    function automatic logic [7:0] status_of(input logic [3:0] step);
        return {4'b1100, step};
    endfunction

endpackage

// File: rtl/mgmt_resp_timer.sv
module mgmt_resp_timer #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNTW = (DELAY < 2) ? 1 : $clog2(DELAY);

    typedef struct packed {
        logic            run;
        logic [CNTW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign done = q.run && (q.cnt == '0);

    always_comb begin
        d = q;
        if (start && !q.run) begin
            d.run = 1'b1;
            d.cnt = CNTW'(DELAY - 1);
        end else if (q.run) begin
            if (q.cnt == '0) d.run = 1'b0;
            else             d.cnt = q.cnt - CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mgmt_byte_buf.sv
module mgmt_byte_buf #(
    parameter int DEPTH = 16,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [7:0]      wdata,
    input  logic [IDXW-1:0] raddr,
    output logic [7:0]      rdata
);
    logic [7:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)                             mem_q[i] <= 8'h00;
            else if (we && (waddr == IDXW'(i)))     mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mgmt_port_responder.sv
module mgmt_port_responder
    import mgmt_pkg::*;
#(
    parameter int BUF_DEPTH  = 16,
    parameter int RESP_DELAY = 4,
    parameter int IDXW       = $clog2(BUF_DEPTH),
    parameter int LENW       = $clog2(BUF_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            sms_avail_i,
    input  logic            rsp_load,
    input  logic [IDXW-1:0] rsp_load_idx,
    input  logic [7:0]      rsp_load_byte,
    input  logic [LENW-1:0] rsp_len,
    input  logic [IDXW-1:0] req_peek_idx,
    output logic [7:0]      req_peek_byte,
    output logic [LENW-1:0] req_count
);
    localparam logic [LENW-1:0] FULL_CNT = LENW'(BUF_DEPTH);
    localparam logic [LENW-1:0] MIN_RSP  = LENW'(2);

    typedef struct packed {
        phase_t          phase;
        logic [7:0]      status;
        logic [7:0]      dout;
        logic [7:0]      ctrl;
        logic [7:0]      hin;
        logic            rx;
        logic            tx;
        logic            busy;
        logic [LENW-1:0] wcnt;
        logic [LENW-1:0] rptr;
    } st_t;

    st_t q, d;

    logic            tmr_go, tmr_done;
    logic            req_we;
    logic [IDXW-1:0] req_wa;
    logic [IDXW-1:0] rsp_ra;
    logic [7:0]      rsp_byte;
    logic [3:0]      code;
    logic            form_ok, illegal, full;
    logic [LENW-1:0] wnext;

    mgmt_resp_timer #(.DELAY(RESP_DELAY)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_go), .done(tmr_done)
    );

    mgmt_byte_buf #(.DEPTH(BUF_DEPTH), .IDXW(IDXW)) u_req (
        .clk(clk), .rst_n(rst_n), .we(req_we), .waddr(req_wa), .wdata(q.hin),
        .raddr(req_peek_idx), .rdata(req_peek_byte)
    );

    mgmt_byte_buf #(.DEPTH(BUF_DEPTH), .IDXW(IDXW)) u_rsp (
        .clk(clk), .rst_n(rst_n), .we(rsp_load), .waddr(rsp_load_idx),
        .wdata(rsp_load_byte), .raddr(rsp_ra), .rdata(rsp_byte)
    );

    always_comb begin
        d       = q;
        tmr_go  = 1'b0;
        req_we  = 1'b0;
        req_wa  = q.wcnt[IDXW-1:0];
        illegal = 1'b0;
        full    = 1'b0;
        code    = q.ctrl[3:0];
        form_ok = (q.ctrl[7:4] == CTRL_HI);
        wnext   = q.wcnt + LENW'(1);
        rsp_ra  = (code == STEP_RD_START) ? '0 : q.rptr[IDXW-1:0];

        // host register writes, accepted only when idle
        if (bus_wr && !q.busy) begin
            case (bus_addr)
                ADDR_DATA: d.hin  = bus_wdata;
                ADDR_CTRL: d.ctrl = bus_wdata;
                ADDR_FLAGS: if (bus_wdata[0]) begin
                    d.busy = 1'b1;
                    tmr_go = 1'b1;
                end
                default: ;
            endcase
        end

        // command completion
        if (tmr_done) begin
            d.busy = 1'b0;
            if (!form_ok) begin
                illegal = 1'b1;
            end else begin
                case (code)
                    STEP_READY: begin
                        if (q.phase == PH_READY) begin
                            d.status = status_of(STEP_READY);
                            d.dout   = CC_OK;
                            d.rx     = 1'b0;
                            d.tx     = 1'b0;
                        end else illegal = 1'b1;
                    end
                    STEP_WR_START: begin
                        if (q.phase == PH_READY) begin
                            req_we   = 1'b1;
                            req_wa   = '0;
                            d.wcnt   = LENW'(1);
                            d.status = status_of(STEP_WR_START);
                            d.dout   = CC_OK;
                            d.tx     = (LENW'(1) < FULL_CNT);
                            d.rx     = 1'b0;
                            d.phase  = PH_WRITE;
                        end else illegal = 1'b1;
                    end
                    STEP_WR_NEXT: begin
                        if (q.phase != PH_WRITE) illegal = 1'b1;
                        else if (q.wcnt == FULL_CNT) full = 1'b1;
                        else begin
                            req_we   = 1'b1;
                            d.wcnt   = wnext;
                            d.status = status_of(STEP_WR_NEXT);
                            d.dout   = CC_OK;
                            d.tx     = (wnext < FULL_CNT);
                        end
                    end
                    STEP_WR_END: begin
                        if (q.phase != PH_WRITE) illegal = 1'b1;
                        else if (q.wcnt == FULL_CNT) full = 1'b1;
                        else begin
                            req_we   = 1'b1;
                            d.wcnt   = wnext;
                            d.status = status_of(STEP_WR_END);
                            d.dout   = CC_OK;
                            d.tx     = 1'b0;
                            d.rx     = (rsp_len >= MIN_RSP);
                            d.phase  = (rsp_len >= MIN_RSP) ? PH_RESP : PH_READY;
                        end
                    end
                    STEP_RD_START: begin
                        if (q.phase == PH_RESP) begin
                            d.dout   = rsp_byte;
                            d.rptr   = LENW'(1);
                            d.status = status_of(STEP_RD_START);
                            d.rx     = 1'b1;
                            d.phase  = PH_READ;
                        end else illegal = 1'b1;
                    end
                    STEP_RD_NEXT: begin
                        if (q.phase == PH_READ && q.rptr < rsp_len) begin
                            d.dout   = rsp_byte;
                            d.rptr   = q.rptr + LENW'(1);
                            d.status = (q.rptr == rsp_len - LENW'(1)) ?
                                       status_of(STEP_RD_END) : status_of(STEP_RD_NEXT);
                            d.rx     = 1'b1;
                        end else illegal = 1'b1;
                    end
                    STEP_RD_END: begin
                        if (q.phase == PH_READ && q.rptr == rsp_len) begin
                            d.status = status_of(STEP_READY);
                            d.dout   = CC_OK;
                            d.rx     = 1'b0;
                            d.phase  = PH_READY;
                        end else illegal = 1'b1;
                    end
                    default: illegal = 1'b1;
                endcase
            end

            if (illegal || full) begin
                d.phase  = PH_READY;
                d.status = status_of(STEP_READY);
                d.dout   = full ? CC_FULL : CC_ILLEGAL;
                d.rx     = 1'b0;
                d.tx     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.phase  <= PH_READY;
            q.status <= status_of(STEP_READY);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA:  bus_rdata = q.dout;
            ADDR_CTRL:  bus_rdata = q.status;
            ADDR_FLAGS: bus_rdata = {q.rx, q.tx, 3'b000, sms_avail_i, 1'b0, q.busy};
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign req_count = q.wcnt;

    // plain nets for the bound checker
    logic       mon_busy;
    logic [7:0] mon_status;
    logic [7:0] mon_dout;
    assign mon_busy   = q.busy;
    assign mon_status = q.status;
    assign mon_dout   = q.dout;
endmodule

// File: rtl/mgmt_port_responder_chk.sv
module mgmt_port_responder_chk #(
    parameter int BUF_DEPTH  = 16,
    parameter int RESP_DELAY = 4,
    parameter int LENW       = $clog2(BUF_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            set_req,
    input logic            busy,
    input logic            done,
    input logic [7:0]      status,
    input logic [7:0]      dout,
    input logic [LENW-1:0] req_count
);
    localparam int BW = $clog2(RESP_DELAY + 2);

    logic [BW-1:0] bcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt_q <= '0;
        else if (busy) bcnt_q <= bcnt_q + BW'(1);
        else           bcnt_q <= '0;
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == BW'(RESP_DELAY)));

    // R3
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt_q < BW'(RESP_DELAY)));

    // R3
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(set_req));

    // R3
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R4
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(status) && $stable(dout)));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_count <= LENW'(BUF_DEPTH));
endmodule

bind mgmt_port_responder mgmt_port_responder_chk #(
    .BUF_DEPTH(BUF_DEPTH), .RESP_DELAY(RESP_DELAY), .LENW(LENW)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .set_req(bus_wr && (bus_addr == 2'd2) && bus_wdata[0]),
    .busy(mon_busy), .done(tmr_done),
    .status(mon_status), .dout(mon_dout), .req_count(req_count)
);

// File: tb/mgmt_port_responder_tb_top.sv
module mgmt_port_responder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int DLY   = 3;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int LENW  = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            sms_avail_i = 1'b0;
    logic            rsp_load = 1'b0;
    logic [IDXW-1:0] rsp_load_idx = '0;
    logic [7:0]      rsp_load_byte = '0;
    logic [LENW-1:0] rsp_len = '0;
    logic [IDXW-1:0] req_peek_idx = '0;
    logic [7:0]      req_peek_byte;
    logic [LENW-1:0] req_count;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_port_responder #(.BUF_DEPTH(DEPTH), .RESP_DELAY(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sms_avail_i(sms_avail_i),
        .rsp_load(rsp_load), .rsp_load_idx(rsp_load_idx),
        .rsp_load_byte(rsp_load_byte), .rsp_len(rsp_len),
        .req_peek_idx(req_peek_idx), .req_peek_byte(req_peek_byte),
        .req_count(req_count)
    );

    // {control, data in, expected status, expected data, expected flags}
    localparam int NV = 15;
    localparam logic [39:0] VEC [NV] = '{
        {8'h40, 8'h00, 8'hC0, 8'h00, 8'h00},  // R5
        {8'h41, 8'h18, 8'hC1, 8'h00, 8'h40},  // R6
        {8'h42, 8'h01, 8'hC2, 8'h00, 8'h40},  // R6
        {8'h43, 8'h55, 8'hC3, 8'h00, 8'h80},  // R7
        {8'h44, 8'h00, 8'hC4, 8'h1C, 8'h80},  // R8
        {8'h45, 8'h00, 8'hC5, 8'h01, 8'h80},  // R8
        {8'h45, 8'h00, 8'hC5, 8'h00, 8'h80},  // R8
        {8'h45, 8'h00, 8'hC6, 8'hAA, 8'h80},  // R8
        {8'h46, 8'h00, 8'hC0, 8'h00, 8'h00},  // R9
        {8'h45, 8'h00, 8'hC0, 8'h02, 8'h00},  // R10 wrong phase
        {8'h41, 8'h77, 8'hC1, 8'h00, 8'h40},  // R6
        {8'h44, 8'h00, 8'hC0, 8'h02, 8'h00},  // R10 read start while writing
        {8'h61, 8'h00, 8'hC0, 8'h02, 8'h00},  // R10 other stream
        {8'hC1, 8'h00, 8'hC0, 8'h02, 8'h00},  // R10 bit 7 set
        {8'h47, 8'h00, 8'hC0, 8'h02, 8'h00}   // R10 undefined step
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic cmd(input logic [7:0] c, input logic [7:0] din);
        wr(2'd0, din);
        wr(2'd1, c);
        wr(2'd2, 8'h01);
        repeat (DLY) @(negedge clk);
    endtask

    task automatic load(input int i, input logic [7:0] b);
        rsp_load = 1'b1; rsp_load_idx = IDXW'(i); rsp_load_byte = b;
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    task automatic expect3(input string req, input logic [7:0] st,
                           input logic [7:0] dt, input logic [7:0] fl);
        logic [7:0] v;
        rd(2'd1, v); check(req, v, st);
        rd(2'd0, v); check(req, v, dt);
        rd(2'd2, v); check(req, v, fl);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect3("R1", 8'hC0, 8'h00, 8'h00);

        // R2 flags bit 2 follows input, reserved bits stay zero
        sms_avail_i = 1'b1;
        rd(2'd2, v); check("R2", v, 8'h04);
        sms_avail_i = 1'b0;

        // R12 response preload
        load(0, 8'h1C); load(1, 8'h01); load(2, 8'h00); load(3, 8'hAA);
        rsp_len = LENW'(4);

        // vector walk R5..R10
        for (int i = 0; i < NV; i++) begin
            cmd(VEC[i][39:32], VEC[i][31:24]);
            expect3($sformatf("R5-R10 vec%0d", i), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R3 busy timing
        wr(2'd1, 8'h40);
        wr(2'd2, 8'h01);
        rd(2'd2, v); check("R3 busy set", v, 8'h01);
        repeat (DLY - 1) @(negedge clk);
        rd(2'd2, v); check("R3 busy held", v, 8'h01);
        @(negedge clk);
        rd(2'd2, v); check("R3 busy cleared", v, 8'h00);

        // R4 writes during busy ignored
        wr(2'd0, 8'h33);
        wr(2'd1, 8'h41);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h47);
        wr(2'd0, 8'h99);
        @(negedge clk);
        expect3("R4", 8'hC1, 8'h00, 8'h40);
        req_peek_idx = '0; #1;
        check("R4 byte", req_peek_byte, 8'h33);

        // R12 request capture
        cmd(8'h40, 8'h00);
        cmd(8'h41, 8'h18); cmd(8'h42, 8'h01); cmd(8'h43, 8'h55);
        check("R12 count", 8'(req_count), 8'd3);
        req_peek_idx = IDXW'(0); #1; check("R12 b0", req_peek_byte, 8'h18);
        req_peek_idx = IDXW'(1); #1; check("R12 b1", req_peek_byte, 8'h01);
        req_peek_idx = IDXW'(2); #1; check("R12 b2", req_peek_byte, 8'h55);

        // R11 overflow with depth 4
        cmd(8'h40, 8'h00);
        cmd(8'h41, 8'hA0); cmd(8'h42, 8'hA1); cmd(8'h42, 8'hA2);
        rd(2'd2, v); check("R6 room", v, 8'h40);
        cmd(8'h42, 8'hA3);
        rd(2'd2, v); check("R6 no room", v, 8'h00);
        cmd(8'h42, 8'hA4);
        expect3("R11", 8'hC0, 8'h05, 8'h00);
        check("R11 count", 8'(req_count), 8'd4);
        req_peek_idx = IDXW'(3); #1; check("R11 byte", req_peek_byte, 8'hA3);

        // R7 short response: no response ready flag
        rsp_len = LENW'(1);
        cmd(8'h41, 8'h10); cmd(8'h43, 8'h11);
        expect3("R7 short", 8'hC3, 8'h00, 8'h00);
        cmd(8'h44, 8'h00);
        expect3("R10 no response", 8'hC0, 8'h02, 8'h00);

        // R9 read end before last byte is illegal
        rsp_len = LENW'(3);
        cmd(8'h41, 8'h20); cmd(8'h43, 8'h21); cmd(8'h44, 8'h00);
        cmd(8'h46, 8'h00);
        expect3("R9 early end", 8'hC0, 8'h02, 8'h00);

        finish_run();
    end
endmodule